// File: doc/BRIEF.md
# Serial Packet Receive Terminator

This block takes the byte stream coming out of a UART receiver and turns it into payload frames for a DMA write path. Every incoming byte is classified as header, payload, delimiter or check byte. Payload bytes are forwarded, and the block decides when the current payload is over. The end-of-payload rule is chosen at run time from configuration inputs. The payload can end on a separator byte, on a byte count, on a line-idle indication or on a received break. In count mode the target length is taken from a 4-byte packet header when header parsing is enabled, and from a configuration word otherwise.

The last forwarded payload byte is marked with an end-of-frame flag. A termination with no payload byte still waiting produces a data-less end-of-frame strobe. When check mode is enabled, two trailing bytes carry a 16-bit CCITT CRC over the payload. A mismatch raises a one-cycle error pulse alongside the end-of-frame indication, and reception then continues with the next packet.

The block relies on three conditions in its environment:
- Input bytes are at most one every other cycle, which holds for any UART rate.
- Configuration stays stable while a packet is in progress.
- Without a header, the configured length is at least 1.

Top module: `pkt_rx_term`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_eof and crc_err are low.
- R2: With count mode off, byte value 0xC0 in the payload ends the frame. The 0xC0 byte is not forwarded, and the last forwarded byte has out_eof high in the same cycle as its out_valid.
- R3: With count mode on and header parsing off, the frame ends after exactly cfg_len payload bytes. A 0xC0 byte is forwarded as ordinary data in this mode.
- R4: With header parsing on, the first 4 bytes of a packet are consumed and not forwarded. Header byte 2 is the low byte and header byte 3 the high byte of the payload length, and in count mode this length sets the frame size.
- R5: With header parsing on and count mode off, the header length field is ignored and the payload ends at 0xC0. A 0xC0 byte inside the header does not end the frame.
- R6: With idle termination enabled, a line_idle pulse ends the frame and flushes the waiting byte with out_eof. With idle termination disabled, a line_idle pulse produces no output.
- R7: With break termination enabled, a line_break pulse ends the frame. If no payload byte is waiting, an end-of-frame strobe is issued with out_valid low.
- R8: With check mode on, two bytes (high byte first) follow the payload and are not forwarded. The CRC uses polynomial 0x1021, initial value 0xFFFF and MSB-first order over the payload bytes. On a match, out_eof comes with the last payload byte and crc_err stays low.
- R9: On a CRC mismatch, crc_err is high for exactly one cycle, together with out_eof. The next packet is then received normally.
- R10: A fsm_clr pulse returns the receiver to waiting for a new packet. Any waiting payload byte is discarded without output, and the outputs are low in the following cycle.
- R11: A frame with no payload bytes produces one end-of-frame strobe with out_valid low. Such a frame is either a leading 0xC0 in delimiter mode or a header with length 0 in count mode.
- R12: line_idle and line_break pulses arriving before the first byte of a packet produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsm_clr | input | 1 | Synchronous clear of the receive state machine |
| cfg_len_mode | input | 1 | 1: count-based end, 0: 0xC0 separator end |
| cfg_hdr_en | input | 1 | Parse a 4-byte header before the payload |
| cfg_len | input | 16 | Payload length used when header parsing is off |
| cfg_idle_end | input | 1 | Allow line idle to end the frame |
| cfg_brk_end | input | 1 | Allow a break to end the frame |
| cfg_crc_en | input | 1 | Expect and check a trailing 16-bit CRC |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| line_idle | input | 1 | UART idle indication (pulse) |
| line_break | input | 1 | UART break/NULL frame indication (pulse) |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| out_eof | output | 1 | End-of-frame marker |
| crc_err | output | 1 | One-cycle CRC mismatch pulse |

## Verification
The hardest situation to reach is a data-less end-of-frame from a break. It needs a packet that has started while no payload byte is held back for output. In delimiter mode a byte is held almost all the time, so the bench opens a packet in header-plus-count mode, sends only the four header bytes and then pulses line_break. A second hard case is a byte held back when fsm_clr arrives. The bench leaves one byte waiting, pulses the clear and then sends a lone 0xC0, which must yield an empty strobe rather than the discarded byte.

// File: rtl/pkt_rx_pkg.sv
// Package: shared types and the CRC step for the packet receive terminator.
// Assumes MSB-first CRC processing, one byte per call.
package pkt_rx_pkg;

    localparam int LEN_W = 16;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_HDR,
        ST_PAY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_TAIL
    } rx_state_e;

    // Advance a 16-bit CRC by one byte, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  data,
                                               input logic [15:0] poly);
        logic [15:0] acc;
        logic        fb;
        acc = cur;
        for (int i = 7; i >= 0; i--) begin
            fb  = acc[15] ^ data[i];
            acc = {acc[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
        end
        return acc;
    endfunction

endpackage

// File: rtl/prx_crc16.sv
// Module: running CRC over payload bytes.
// Assumes clr and upd are never asserted together (clr wins if they are).
module prx_crc16
    import pkt_rx_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Accumulate the CRC for each accepted payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= SEED;
        end else if (upd) begin
            crc <= crc16_step(crc, din, POLY);
        end
    end

endmodule

// File: rtl/prx_len_track.sv
// Module: payload byte counter with terminal-byte detection.
// Assumes the target is stable during a packet; last flags the byte that
// would make the count reach the target.
module prx_len_track
    import pkt_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] target,
    output logic             last
);

    logic [LEN_W-1:0] cnt;
    logic [LEN_W:0]   cnt_next;

    // Count accepted payload bytes of the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare the would-be count with the target.
    always_comb begin
        cnt_next = {1'b0, cnt} + 1'b1;
        last     = (cnt_next == {1'b0, target});
    end

endmodule

// File: rtl/prx_hold_stage.sv
// Module: one-byte hold-back output stage.
// A byte is held until the next byte proves it is not last, or until a
// finish request marks it as end of frame. Assumes push and fin are exclusive.
module prx_hold_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       fin,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_eof
);

    logic       pend;
    logic [7:0] pend_byte;

    // Release the held byte on push or finish, and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend      <= 1'b0;
            pend_byte <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            if (push) begin
                out_valid <= pend;
                out_byte  <= pend_byte;
                pend      <= 1'b1;
                pend_byte <= din;
            end else if (fin) begin
                out_valid <= pend;
                out_byte  <= pend_byte;
                out_eof   <= 1'b1;
                pend      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pkt_rx_term.sv
// Module: serial packet receive terminator (top).
// Classifies UART bytes as header, payload, separator or CRC, forwards payload
// and decides the end of frame. Assumes at most one input byte every two
// cycles and configuration stable during a packet. Priority within a cycle:
// an enabled idle/break event beats a concurrent byte, which is dropped.
module pkt_rx_term
    import pkt_rx_pkg::*;
#(
    parameter int          HDR_BYTES = 4,
    parameter logic [7:0]  DELIM     = 8'hC0,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_SEED  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsm_clr,
    input  logic             cfg_len_mode,
    input  logic             cfg_hdr_en,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_idle_end,
    input  logic             cfg_brk_end,
    input  logic             cfg_crc_en,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             line_idle,
    input  logic             line_break,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_eof,
    output logic             crc_err
);

    localparam int HDR_IDX_W = $clog2(HDR_BYTES);
    localparam logic [HDR_IDX_W-1:0] IDX_LO   = HDR_IDX_W'(HDR_BYTES - 2);
    localparam logic [HDR_IDX_W-1:0] IDX_LAST = HDR_IDX_W'(HDR_BYTES - 1);

    rx_state_e            st, st_nxt;
    logic [HDR_IDX_W-1:0] hdr_idx, hdr_idx_nxt;
    logic [LEN_W-1:0]     hdr_len;
    logic [7:0]           crc_hi;
    logic [15:0]          crc_val;
    logic [LEN_W-1:0]     len_target;
    logic                 len_last;
    logic                 term_ev, is_delim, take_pay;
    logic                 do_push, do_fin, err_now, crc_upd, len_inc;
    logic                 go_wait, end_req, load_lo, load_hi, hi_cap;
    logic                 cnt_clr;

    // Pick the length source according to header mode.
    always_comb begin
        len_target = cfg_hdr_en ? hdr_len : cfg_len;
        term_ev    = (cfg_brk_end & line_break) | (cfg_idle_end & line_idle);
        is_delim   = !cfg_len_mode && (in_byte == DELIM);
    end

    // Decide the next state and the actions for this cycle.
    always_comb begin
        st_nxt      = st;
        hdr_idx_nxt = hdr_idx;
        do_push     = 1'b0;
        do_fin      = 1'b0;
        err_now     = 1'b0;
        crc_upd     = 1'b0;
        len_inc     = 1'b0;
        go_wait     = 1'b0;
        end_req     = 1'b0;
        load_lo     = 1'b0;
        load_hi     = 1'b0;
        hi_cap      = 1'b0;
        take_pay    = 1'b0;
        case (st)
            ST_WAIT: begin
                if (in_valid && cfg_hdr_en) begin
                    st_nxt      = ST_HDR;
                    hdr_idx_nxt = HDR_IDX_W'(1);
                end else if (in_valid) begin
                    take_pay = 1'b1;
                end
            end
            ST_HDR: begin
                if (term_ev) begin
                    do_fin  = 1'b1;
                    go_wait = 1'b1;
                end else if (in_valid) begin
                    load_lo     = (hdr_idx == IDX_LO);
                    hdr_idx_nxt = hdr_idx + 1'b1;
                    if (hdr_idx == IDX_LAST) begin
                        load_hi = 1'b1;
                        if (cfg_len_mode && ({in_byte, hdr_len[7:0]} == 16'h0000)) begin
                            end_req = 1'b1;
                        end else begin
                            st_nxt = ST_PAY;
                        end
                    end
                end
            end
            ST_PAY: begin
                if (term_ev) begin
                    do_fin  = 1'b1;
                    go_wait = 1'b1;
                end else if (in_valid) begin
                    take_pay = 1'b1;
                end
            end
            ST_CRC_HI: begin
                if (term_ev) begin
                    do_fin  = 1'b1;
                    go_wait = 1'b1;
                end else if (in_valid) begin
                    hi_cap = 1'b1;
                    st_nxt = ST_CRC_LO;
                end
            end
            ST_CRC_LO: begin
                if (term_ev) begin
                    do_fin  = 1'b1;
                    go_wait = 1'b1;
                end else if (in_valid) begin
                    do_fin  = 1'b1;
                    err_now = ({crc_hi, in_byte} != crc_val);
                    go_wait = 1'b1;
                end
            end
            ST_TAIL: begin
                do_fin  = 1'b1;
                go_wait = 1'b1;
            end
            default: go_wait = 1'b1;
        endcase
        if (take_pay) begin
            if (is_delim) begin
                end_req = 1'b1;
            end else begin
                do_push = 1'b1;
                crc_upd = 1'b1;
                len_inc = 1'b1;
                if (cfg_len_mode && len_last) begin
                    st_nxt = cfg_crc_en ? ST_CRC_HI : ST_TAIL;
                end else begin
                    st_nxt = ST_PAY;
                end
            end
        end
        if (end_req) begin
            if (cfg_crc_en) begin
                st_nxt = ST_CRC_HI;
            end else begin
                do_fin  = 1'b1;
                go_wait = 1'b1;
            end
        end
        if (go_wait) begin
            st_nxt = ST_WAIT;
        end
    end

    // Hold state, header index, header length and the CRC high byte.
    always_ff @(posedge clk) begin
        if (!rst_n || fsm_clr) begin
            st      <= ST_WAIT;
            hdr_idx <= '0;
            hdr_len <= '0;
            crc_hi  <= '0;
            crc_err <= 1'b0;
        end else begin
            st      <= st_nxt;
            hdr_idx <= hdr_idx_nxt;
            crc_err <= err_now;
            if (load_lo) hdr_len[7:0]  <= in_byte;
            if (load_hi) hdr_len[15:8] <= in_byte;
            if (hi_cap)  crc_hi        <= in_byte;
        end
    end

    assign cnt_clr = fsm_clr | go_wait;

    prx_crc16 #(
        .POLY (CRC_POLY),
        .SEED (CRC_SEED)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .upd   (crc_upd),
        .din   (in_byte),
        .crc   (crc_val)
    );

    prx_len_track u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (len_inc),
        .target (len_target),
        .last   (len_last)
    );

    prx_hold_stage u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fsm_clr),
        .push      (do_push),
        .din       (in_byte),
        .fin       (do_fin),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_eof   (out_eof)
    );

endmodule

// File: rtl/prx_checker.sv
// Module: assertion checker for pkt_rx_term, attached by bind.
// Assumes configuration is stable while frames are being emitted.
module prx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fsm_clr,
    input logic       cfg_len_mode,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_eof,
    input logic       crc_err
);

    AST_ERR_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> out_eof); // R9

    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err); // R9

    AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_clr |=> (!out_valid && !out_eof && !crc_err)); // R10

    AST_NO_SEPARATOR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_len_mode) |-> (out_byte != 8'hC0)); // R2

endmodule

bind pkt_rx_term prx_checker u_prx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fsm_clr      (fsm_clr),
    .cfg_len_mode (cfg_len_mode),
    .out_valid    (out_valid),
    .out_byte     (out_byte),
    .out_eof      (out_eof),
    .crc_err      (crc_err)
);

// File: tb/pkt_rx_term_tb.sv
// Bench: scoreboard for pkt_rx_term. Driver tasks queue expected outputs,
// a monitor pops and compares them whenever the design emits something.
module pkt_rx_term_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic       v;
        logic [7:0] b;
        logic       eof;
        logic       err;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsm_clr = 1'b0;
    logic        cfg_len_mode = 1'b0;
    logic        cfg_hdr_en = 1'b0;
    logic [15:0] cfg_len = 16'd1;
    logic        cfg_idle_end = 1'b0;
    logic        cfg_brk_end = 1'b0;
    logic        cfg_crc_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        line_idle = 1'b0;
    logic        line_break = 1'b0;
    logic        out_valid, out_eof, crc_err;
    logic [7:0]  out_byte;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_rx_term u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fsm_clr      (fsm_clr),
        .cfg_len_mode (cfg_len_mode),
        .cfg_hdr_en   (cfg_hdr_en),
        .cfg_len      (cfg_len),
        .cfg_idle_end (cfg_idle_end),
        .cfg_brk_end  (cfg_brk_end),
        .cfg_crc_en   (cfg_crc_en),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .line_idle    (line_idle),
        .line_break   (line_break),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .out_eof      (out_eof),
        .crc_err      (crc_err)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) begin
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    task automatic expect_item(input logic v, input logic [7:0] b, input logic eof,
                               input logic err, input string tag);
        exp_t e;
        e.v = v; e.b = b; e.eof = eof; e.err = err; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_idle();
        @(negedge clk);
        line_idle = 1'b1;
        @(negedge clk);
        line_idle = 1'b0;
    endtask

    task automatic pulse_break();
        @(negedge clk);
        line_break = 1'b1;
        @(negedge clk);
        line_break = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compare each design output event against the queue head.
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_eof || crc_err)) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected output: valid=%0b byte=%02h eof=%0b err=%0b expected none",
                         out_valid, out_byte, out_eof, crc_err);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (out_valid !== e.v || out_eof !== e.eof || crc_err !== e.err ||
                    (e.v && out_byte !== e.b)) begin
                    n_bad++;
                    $display("FAIL %s: got valid=%0b byte=%02h eof=%0b err=%0b expected valid=%0b byte=%02h eof=%0b err=%0b",
                             e.tag, out_valid, out_byte, out_eof, crc_err, e.v, e.b, e.eof, e.err);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        n_chk++;
        if (out_valid !== 1'b0 || out_eof !== 1'b0 || crc_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got valid=%0b eof=%0b err=%0b expected 0 0 0",
                     out_valid, out_eof, crc_err);
        end

        // R2: separator ends frame, separator dropped
        expect_item(1, 8'h11, 0, 0, "R2");
        expect_item(1, 8'h22, 0, 0, "R2");
        expect_item(1, 8'h33, 1, 0, "R2");
        send(8'h11); send(8'h22); send(8'h33); send(8'hC0);
        settle();

        // R11: leading separator gives an empty strobe
        expect_item(0, 8'h00, 1, 0, "R11");
        send(8'hC0);
        settle();

        // R3: configured length, 0xC0 is data
        cfg_len_mode = 1'b1; cfg_len = 16'd3;
        expect_item(1, 8'h44, 0, 0, "R3");
        expect_item(1, 8'hC0, 0, 0, "R3");
        expect_item(1, 8'h55, 1, 0, "R3");
        send(8'h44); send(8'hC0); send(8'h55);
        settle();

        // R4: header length little-endian in bytes 2 and 3
        cfg_hdr_en = 1'b1;
        expect_item(1, 8'h66, 0, 0, "R4");
        expect_item(1, 8'h77, 1, 0, "R4");
        send(8'hAA); send(8'hBB); send(8'h02); send(8'h00);
        send(8'h66); send(8'h77);
        settle();

        // R11: header length zero
        expect_item(0, 8'h00, 1, 0, "R11");
        send(8'h01); send(8'h02); send(8'h00); send(8'h00);
        settle();

        // R5: header with separator mode, 0xC0 inside header ignored
        cfg_len_mode = 1'b0;
        expect_item(1, 8'h88, 1, 0, "R5");
        send(8'hC0); send(8'hC0); send(8'h05); send(8'h00);
        send(8'h88); send(8'hC0);
        settle();

        // R6: idle enabled flushes, idle disabled ignored
        cfg_hdr_en = 1'b0; cfg_idle_end = 1'b1;
        expect_item(1, 8'h12, 0, 0, "R6");
        expect_item(1, 8'h34, 1, 0, "R6");
        send(8'h12); send(8'h34); pulse_idle();
        settle();
        cfg_idle_end = 1'b0;
        expect_item(1, 8'h56, 1, 0, "R6");
        send(8'h56); pulse_idle(); settle();
        send(8'hC0);
        settle();

        // R7: break after header only gives empty strobe
        cfg_brk_end = 1'b1; cfg_hdr_en = 1'b1; cfg_len_mode = 1'b1;
        expect_item(0, 8'h00, 1, 0, "R7");
        send(8'h00); send(8'h00); send(8'h05); send(8'h00);
        pulse_break();
        settle();
        // R7: break flushes a waiting byte
        cfg_hdr_en = 1'b0; cfg_len_mode = 1'b0;
        expect_item(1, 8'h9A, 1, 0, "R7");
        send(8'h9A); pulse_break();
        settle();

        // R12: idle and break before any byte are ignored
        cfg_idle_end = 1'b1;
        pulse_idle(); pulse_break();
        settle();
        cfg_idle_end = 1'b0; cfg_brk_end = 1'b0;

        // R8: good CRC over "123456789", separator mode
        cfg_crc_en = 1'b1;
        c = 16'hFFFF;
        for (int i = 0; i < 9; i++) begin
            c = ref_crc(c, 8'h31 + 8'(i));
            expect_item(1, 8'h31 + 8'(i), (i == 8), 0, "R8");
        end
        for (int i = 0; i < 9; i++) send(8'h31 + 8'(i));
        send(8'hC0); send(c[15:8]); send(c[7:0]);
        settle();

        // R9: bad CRC, count mode, then recovery
        cfg_len_mode = 1'b1; cfg_len = 16'd2;
        c = ref_crc(ref_crc(16'hFFFF, 8'h01), 8'h02);
        expect_item(1, 8'h01, 0, 0, "R9");
        expect_item(1, 8'h02, 1, 1, "R9");
        send(8'h01); send(8'h02); send(c[15:8]); send(c[7:0] ^ 8'h01);
        settle();
        cfg_len = 16'd1;
        c = ref_crc(16'hFFFF, 8'h03);
        expect_item(1, 8'h03, 1, 0, "R9");
        send(8'h03); send(c[15:8]); send(c[7:0]);
        settle();

        // R10: clear discards waiting byte
        cfg_crc_en = 1'b0; cfg_len_mode = 1'b0;
        expect_item(1, 8'hA1, 0, 0, "R10");
        expect_item(0, 8'h00, 1, 0, "R10");
        send(8'hA1); send(8'hA2);
        @(negedge clk); fsm_clr = 1'b1;
        @(negedge clk); fsm_clr = 1'b0;
        send(8'hC0);
        settle();

        // All expected items consumed
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL queue drain: got %0d left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule